// File: doc/BRIEF.md
# Turn-Signal Tail Light Sequencer

This block drives six tail lamps, three on each side of a vehicle, for left-turn, right-turn and hazard indications. It is a Moore machine that moves only when a one-cycle step tick arrives. The tick comes from a divider outside the block, for example one pulse every 300 ms derived from a 50 MHz clock by dividing by 15,000,000. Each lamp pattern therefore stays on for exactly one step interval.

A turn request starts a sweep that lights the lamps of that side one more at a time, working outward from the centre of the car. Once a sweep has started it always reaches its final pattern, whatever the turn inputs do later. A hazard request overrides a sweep at the next tick and flashes all six lamps on and off in turn. At the end of a sweep, and after the off phase of a hazard flash, the machine checks its inputs again with hazard first, then left, then right. If none is active it goes dark. The lamp vector is registered and is updated in the same clock edge as the state.

Top module: `tail_lamp_seq`

## Requirements
- R1: While `rst` is sampled high on a rising clock edge, the lamps read 000000 after that edge, and the machine is idle.
- R2: On edges where `step_tick` is low, the lamp vector does not change, whatever the request inputs do.
- R3: From idle, a tick selects hazard over left and left over right. With no request, the lamps stay 000000.
- R4: The left sweep shows 001000, then 011000, then 111000, one pattern per tick. Bits 5..3 are the left side, with bit 3 innermost.
- R5: The right sweep shows 000100, then 000110, then 000111, one pattern per tick. Bits 2..0 are the right side, with bit 2 innermost.
- R6: A started sweep runs to its last pattern even if its own request drops or the other side's request rises before it ends.
- R7: If hazard is high at a tick during a sweep, the next pattern is 111111 and the sweep is abandoned.
- R8: The hazard flash alternates 111111 and 000000. The all-on phase is always followed by the all-off phase, even if hazard has dropped.
- R9: After a sweep's last pattern, or after the hazard off phase, the next tick re-applies the R3 priority. A turn request that is still held restarts its sweep from its first pattern.
- R10: A new pattern appears on `lamps` in the clock cycle right after the edge that samples the tick, never before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_tick | input | 1 | One-cycle pulse that advances the pattern |
| req_left | input | 1 | Left-turn request |
| req_right | input | 1 | Right-turn request |
| req_hazard | input | 1 | Hazard request |
| lamps | output | 6 | Lamp vector; bits 5..3 are the left side and bits 2..0 the right side |

## Verification
Sweeps are run with their request held steady, with the request dropped partway through, and with the opposite request raised partway through. These runs separate a locked sweep from one that follows its inputs. A held left request must give two sweeps back to back, which shows that the request is sampled again at the end of a sweep. Hazard is raised in the middle of a sweep and dropped during its all-on phase. This shows that hazard takes over immediately while the off phase can still not be skipped. Hazard paired with a turn request, and long gaps between ticks while requests change, check the priority order and that the state holds between ticks.

// File: rtl/tl_pkg.sv
package tl_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE    = 3'd0,
    MODE_HAZ_ON  = 3'd1,
    MODE_HAZ_OFF = 3'd2,
    MODE_LEFT    = 3'd3,
    MODE_RIGHT   = 3'd4
  } mode_e;
endpackage

// File: rtl/tl_seq_ctrl.sv
module tl_seq_ctrl #(
  parameter int SIDE_LAMPS = 3,
  localparam int STEP_W = (SIDE_LAMPS > 1) ? $clog2(SIDE_LAMPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_tick,
  input  logic              req_left,
  input  logic              req_right,
  input  logic              req_hazard,
  output tl_pkg::mode_e     mode_q,
  output logic [STEP_W-1:0] step_q,
  output tl_pkg::mode_e     mode_nxt,
  output logic [STEP_W-1:0] step_nxt
);
  import tl_pkg::*;

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SIDE_LAMPS - 1);
  localparam logic [STEP_W-1:0] ONE_STEP  = STEP_W'(1);

  logic reselect;

  // Candidate next state; the registers take it only on a tick.
  always_comb begin
    mode_nxt = mode_q;
    step_nxt = step_q;
    reselect = 1'b0;
    case (mode_q)
      MODE_HAZ_ON: begin
        mode_nxt = MODE_HAZ_OFF;
        step_nxt = '0;
      end
      MODE_LEFT, MODE_RIGHT: begin
        if (step_q == LAST_STEP) begin
          reselect = 1'b1;
        end else if (req_hazard) begin
          mode_nxt = MODE_HAZ_ON;
          step_nxt = '0;
        end else begin
          step_nxt = step_q + ONE_STEP;
        end
      end
      default: reselect = 1'b1;
    endcase
    if (reselect) begin
      step_nxt = '0;
      if (req_hazard)     mode_nxt = MODE_HAZ_ON;
      else if (req_left)  mode_nxt = MODE_LEFT;
      else if (req_right) mode_nxt = MODE_RIGHT;
      else                mode_nxt = MODE_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_IDLE;
      step_q <= '0;
    end else if (step_tick) begin
      mode_q <= mode_nxt;
      step_q <= step_nxt;
    end
  end

  // R6: an unfinished sweep without hazard keeps its side and advances one step
  p_sweep_locked_r6: assert property (@(posedge clk) disable iff (rst)
    (step_tick && !req_hazard && (mode_q == MODE_LEFT || mode_q == MODE_RIGHT)
     && step_q != LAST_STEP)
    |=> (mode_q == $past(mode_q) && step_q == $past(step_q) + ONE_STEP));

  // R3: a tick with every request low, taken from idle, stays idle
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (step_tick && mode_q == MODE_IDLE && !req_hazard && !req_left && !req_right)
    |=> mode_q == MODE_IDLE);
endmodule

// File: rtl/tl_lamp_map.sv
module tl_lamp_map #(
  parameter int SIDE_LAMPS = 3,
  localparam int STEP_W = (SIDE_LAMPS > 1) ? $clog2(SIDE_LAMPS) : 1,
  localparam int LAMP_W = 2 * SIDE_LAMPS
) (
  input  tl_pkg::mode_e     mode,
  input  logic [STEP_W-1:0] step,
  output logic [LAMP_W-1:0] pattern
);
  import tl_pkg::*;

  logic all_on, left_on, right_on;
  assign all_on   = (mode == MODE_HAZ_ON);
  assign left_on  = (mode == MODE_LEFT);
  assign right_on = (mode == MODE_RIGHT);

  // Lamp i counts outward from the centre on each side.
  for (genvar i = 0; i < SIDE_LAMPS; i++) begin : g_side
    assign pattern[SIDE_LAMPS + i]     = all_on | (left_on  && step >= STEP_W'(i));
    assign pattern[SIDE_LAMPS - 1 - i] = all_on | (right_on && step >= STEP_W'(i));
  end
endmodule

// File: rtl/tail_lamp_seq.sv
module tail_lamp_seq #(
  parameter int SIDE_LAMPS = 3,
  localparam int LAMP_W = 2 * SIDE_LAMPS,
  localparam int STEP_W = (SIDE_LAMPS > 1) ? $clog2(SIDE_LAMPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_tick,
  input  logic              req_left,
  input  logic              req_right,
  input  logic              req_hazard,
  output logic [LAMP_W-1:0] lamps
);
  import tl_pkg::*;

  mode_e             mode_q, mode_nxt;
  logic [STEP_W-1:0] step_q, step_nxt;
  logic [LAMP_W-1:0] pattern_nxt;

  tl_seq_ctrl #(.SIDE_LAMPS(SIDE_LAMPS)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .step_tick  (step_tick),
    .req_left   (req_left),
    .req_right  (req_right),
    .req_hazard (req_hazard),
    .mode_q     (mode_q),
    .step_q     (step_q),
    .mode_nxt   (mode_nxt),
    .step_nxt   (step_nxt)
  );

  tl_lamp_map #(.SIDE_LAMPS(SIDE_LAMPS)) map_i (
    .mode    (mode_nxt),
    .step    (step_nxt),
    .pattern (pattern_nxt)
  );

  // Output register loads the decode of the incoming state, so lamps and state move together.
  always_ff @(posedge clk) begin
    if (rst)            lamps <= '0;
    else if (step_tick) lamps <= pattern_nxt;
  end

  // R1: reset darkens every lamp
  p_reset_dark_r1: assert property (@(posedge clk) rst |=> lamps == '0);

  // R2: no tick, no change
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !step_tick |=> $stable(lamps));

  // R7: hazard at a tick from any state but the on phase lights everything
  p_hazard_preempt_r7: assert property (@(posedge clk) disable iff (rst)
    (step_tick && req_hazard && mode_q != MODE_HAZ_ON) |=> lamps == '1);

  // R8: the on phase is always followed by the off phase
  p_hazard_off_r8: assert property (@(posedge clk) disable iff (rst)
    (step_tick && mode_q == MODE_HAZ_ON) |=> lamps == '0);

  // R4 / R5: both sides lit together only during the hazard on phase
  p_one_side_r4: assert property (@(posedge clk) disable iff (rst)
    (|lamps[LAMP_W-1:SIDE_LAMPS] && |lamps[SIDE_LAMPS-1:0]) |-> &lamps);
endmodule

// File: tb/tail_lamp_seq_tb_top.sv
module tail_lamp_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_tick = 1'b0;
  logic       req_left = 1'b0;
  logic       req_right = 1'b0;
  logic       req_hazard = 1'b0;
  logic [5:0] lamps;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tail_lamp_seq dut_i (
    .clk        (clk),
    .rst        (rst),
    .step_tick  (step_tick),
    .req_left   (req_left),
    .req_right  (req_right),
    .req_hazard (req_hazard),
    .lamps      (lamps)
  );

  task automatic chk(input string req, input logic [5:0] exp);
    checks++;
    if (lamps !== exp) begin
      errors++;
      $display("FAIL %s lamps got %b expected %b", req, lamps, exp);
    end
  endtask

  // Pulse the tick for one cycle; lamps are sampled at the following falling edge.
  task automatic step();
    @(negedge clk) step_tick = 1'b1;
    @(negedge clk) step_tick = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", 6'b000000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", 6'b000000);
  endtask

  task automatic t_hold_and_latency();
    req_left = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2", 6'b000000);
    @(negedge clk) step_tick = 1'b1;
    chk("R10", 6'b000000);
    @(negedge clk) step_tick = 1'b0;
    chk("R10", 6'b001000);
    req_left = 1'b0;
    req_right = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2", 6'b001000);
    req_right = 1'b0;
    step();
    step();
    step();
    chk("R3", 6'b000000);
  endtask

  task automatic t_left_sweep();
    req_left = 1'b1;
    step();
    chk("R4", 6'b001000);
    req_left = 1'b0;
    req_right = 1'b1;
    step();
    chk("R6", 6'b011000);
    step();
    chk("R4", 6'b111000);
    req_right = 1'b0;
    step();
    chk("R9", 6'b000000);
  endtask

  task automatic t_right_sweep();
    req_right = 1'b1;
    step();
    chk("R5", 6'b000100);
    req_right = 1'b0;
    req_left = 1'b1;
    step();
    chk("R6", 6'b000110);
    req_left = 1'b0;
    step();
    chk("R5", 6'b000111);
    step();
    chk("R9", 6'b000000);
  endtask

  task automatic t_repeat();
    req_left = 1'b1;
    step();
    step();
    step();
    chk("R4", 6'b111000);
    step();
    chk("R9", 6'b001000);
    req_left = 1'b0;
    step();
    step();
    chk("R6", 6'b111000);
    step();
    chk("R9", 6'b000000);
  endtask

  task automatic t_priority();
    req_hazard = 1'b1;
    req_right = 1'b1;
    step();
    chk("R3", 6'b111111);
    req_hazard = 1'b0;
    req_right = 1'b0;
    req_left = 1'b1;
    step();
    chk("R8", 6'b000000);
    step();
    chk("R9", 6'b001000);
    req_left = 1'b0;
    step();
    step();
    step();
    chk("R3", 6'b000000);
  endtask

  task automatic t_abort();
    req_right = 1'b1;
    step();
    chk("R5", 6'b000100);
    req_right = 1'b0;
    req_hazard = 1'b1;
    step();
    chk("R7", 6'b111111);
    step();
    chk("R8", 6'b000000);
    req_hazard = 1'b0;
    step();
    chk("R7", 6'b000000);
    req_left = 1'b1;
    step();
    step();
    req_left = 1'b0;
    req_hazard = 1'b1;
    step();
    chk("R7", 6'b111111);
    req_hazard = 1'b0;
    step();
    step();
    chk("R3", 6'b000000);
  endtask

  task automatic t_hazard();
    req_hazard = 1'b1;
    step();
    chk("R8", 6'b111111);
    step();
    chk("R8", 6'b000000);
    step();
    chk("R8", 6'b111111);
    req_hazard = 1'b0;
    step();
    chk("R8", 6'b000000);
    step();
    chk("R3", 6'b000000);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog lamps got %b expected run to end", lamps);
    finish_run();
  end

  initial begin
    t_reset();
    t_hold_and_latency();
    t_left_sweep();
    t_right_sweep();
    t_repeat();
    t_priority();
    t_abort();
    t_hazard();
    t_reset();
    finish_run();
  end
endmodule